// File: doc/BRIEF.md
# UART Interrupt Enable and Source Combiner

This block sits beside a UART's transmit and receive paths. It owns the 8-bit interrupt enable register and turns the UART's raw events and status levels into one active-high interrupt line. Seven bits of the enable register gate interrupt sources. These are receive data ready, transmit holding register empty, receive line errors, modem status changes, a rising edge on the CTS pin, a rising edge on the RTS signal, and reception of a software flow-control Xoff character. The eighth bit is not a source. It selects sleep mode and is passed straight to an output for the power-control logic.

Level sources follow their inputs directly. Event sources are caught in sticky pending flags, and each flag is released only by its own clear strobe. These event sources are the CTS edge, the RTS edge, the Xoff pulse and the transmit-empty condition. The raw pending vector is exported, so a separate identification stage can rank the sources. Masking a source through its enable bit hides it from the interrupt line but never discards its pending state.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, every enable bit is 0, `irq` and `sleep_en` are 0, and `pending` is 0 while the level inputs are low.
- R2: A write (`wr_en` high at a clock edge) loads `wr_data` into the enable register at that edge. Enable bit 4 drives `sleep_en`, never causes an interrupt, and `pending[4]` always reads 0.
- R3: `irq` is high exactly when some bit i in {0,1,2,3,5,6,7} has both `pending[i]` and enable bit i set. It changes in the same cycle as the pending bit or the enable register.
- R4: `pending[0]` follows the `rx_ready` level.
- R5: `pending[2]` is high whenever any of the four `lsr_err` bits (line status error bits 4 down to 1) is set.
- R6: `pending[3]` is high whenever any of the four `msr_delta` bits (modem status change bits 3 down to 0) is set.
- R7: `pending[1]` is set at the edge where `thr_empty` rises. It is also set by a write that turns enable bit 1 from 0 to 1 while `thr_empty` is high. It clears at the next edge after `clr_thr` is strobed or `thr_empty` is low.
- R8: `cts_in` passes through `CTS_SYNC` flops. A 0-to-1 change sets `pending[7]` `CTS_SYNC`+1 edges after it. A line that is already high when reset ends causes no event.
- R9: A 0-to-1 change of `rts_level` sets `pending[6]` at the next edge. A level that is already high when reset ends causes no event.
- R10: A one-cycle `xoff_seen` pulse sets `pending[5]` at the next edge.
- R11: `pending[7]`, `pending[6]` and `pending[5]` stay set until their own strobe arrives (`clr_cts`, `clr_rts`, `clr_xoff` respectively), even if the input falls again. A new event in the same cycle as the strobe wins.
- R12: Clearing an enable bit drops `irq` in the cycle after the write while the matching pending bit stays set. Setting the bit again raises `irq` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Enable register write strobe |
| wr_data | input | 8 | Enable register write value |
| rx_ready | input | 1 | Receive data available level |
| thr_empty | input | 1 | Transmit holding register empty level |
| lsr_err | input | 4 | Receive error status bits |
| msr_delta | input | 4 | Modem status change bits |
| cts_in | input | 1 | CTS pin, asynchronous |
| rts_level | input | 1 | RTS output level, synchronous |
| xoff_seen | input | 1 | One-cycle pulse on Xoff character receipt |
| clr_thr | input | 1 | Clear strobe for transmit-empty pending |
| clr_xoff | input | 1 | Clear strobe for Xoff pending |
| clr_rts | input | 1 | Clear strobe for RTS edge pending |
| clr_cts | input | 1 | Clear strobe for CTS edge pending |
| irq | output | 1 | Combined interrupt, active high |
| pending | output | 8 | Raw pending bits, positions matching the enable bits |
| sleep_en | output | 1 | Sleep mode enable (enable bit 4) |

## Verification
The assertions assume several things about the inputs. `xoff_seen` and the clear strobes are synchronous to `clk`. `wr_en` is sampled only at clock edges. `rts_level` is a synchronous signal, so only `cts_in` needs the synchronizer. The bench meets these assumptions by driving every input, including `cts_in`, on the falling clock edge, by holding Xoff as a one-cycle pulse, and by lowering level inputs between sweeps. The bench sweeps all 256 enable values against each source in isolation and against all sources at once. It also sweeps all 16 codes of both status buses, and compares results with an expectation computed bit by bit.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int IER_W = 8;

  // Enable / pending bit positions (an identification stage decodes these).
  localparam int BIT_RXRDY = 0;
  localparam int BIT_THRE  = 1;
  localparam int BIT_LINE  = 2;
  localparam int BIT_MODEM = 3;
  localparam int BIT_SLEEP = 4;
  localparam int BIT_XOFF  = 5;
  localparam int BIT_RTS   = 6;
  localparam int BIT_CTS   = 7;

  // Bits that are real interrupt sources (everything but sleep).
  localparam logic [IER_W-1:0] SRC_MASK = ~(IER_W'(1) << BIT_SLEEP);

  // Combined interrupt from pending flags and enables.
  function automatic logic irq_any(input logic [IER_W-1:0] pend,
                                   input logic [IER_W-1:0] en);
    return |(pend & en & SRC_MASK);
  endfunction

  // Sticky flag next state: a new event beats a clear in the same cycle.
  function automatic logic flag_next(input logic q, input logic set,
                                     input logic clr);
    return set | (q & ~clr);
  endfunction

endpackage

// File: rtl/uart_irq_enreg.sv
module uart_irq_enreg
  import uart_irq_pkg::*;
#(
  parameter int W = IER_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wr_data;
  end

endmodule

// File: rtl/uart_irq_edge.sv
module uart_irq_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  logic level_w;
  logic prev_q;

  generate
    if (STAGES == 0) begin : g_direct
      assign level_w = din;
    end else begin : g_sync
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else begin
          sh_q[0] <= din;
          for (int i = 1; i < STAGES; i++) sh_q[i] <= sh_q[i-1];
        end
      end
      assign level_w = sh_q[STAGES-1];
    end
  endgenerate

  // Reset value high: a line already high out of reset is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= level_w;
  end

  assign rise = level_w & ~prev_q;

endmodule

// File: rtl/uart_irq_flag.sv
module uart_irq_flag
  import uart_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= flag_next(q, set, clr);
  end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int LSR_W    = 4,
  parameter int MSR_W    = 4,
  parameter int CTS_SYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IER_W-1:0] wr_data,
  input  logic             rx_ready,
  input  logic             thr_empty,
  input  logic [LSR_W-1:0] lsr_err,
  input  logic [MSR_W-1:0] msr_delta,
  input  logic             cts_in,
  input  logic             rts_level,
  input  logic             xoff_seen,
  input  logic             clr_thr,
  input  logic             clr_xoff,
  input  logic             clr_rts,
  input  logic             clr_cts,
  output logic             irq,
  output logic [IER_W-1:0] pending,
  output logic             sleep_en
);

  logic [IER_W-1:0] ier_q;
  logic cts_rise_w, rts_rise_w, thr_rise_w;
  logic thr_arm_w, thr_set_w, thr_clr_w;
  logic line_w, modem_w;
  logic p_thr_q, p_xoff_q, p_rts_q, p_cts_q;

  uart_irq_enreg #(.W(IER_W)) u_enreg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .q(ier_q)
  );

  uart_irq_edge #(.STAGES(CTS_SYNC), .RST_VAL(1'b1)) u_cts_edge (
    .clk(clk), .rst_n(rst_n), .din(cts_in), .rise(cts_rise_w)
  );

  uart_irq_edge #(.STAGES(0), .RST_VAL(1'b1)) u_rts_edge (
    .clk(clk), .rst_n(rst_n), .din(rts_level), .rise(rts_rise_w)
  );

  uart_irq_edge #(.STAGES(0), .RST_VAL(1'b1)) u_thr_edge (
    .clk(clk), .rst_n(rst_n), .din(thr_empty), .rise(thr_rise_w)
  );

  // Turning the enable on while the holding register is already empty
  // raises the request, as the empty edge happened before the enable.
  assign thr_arm_w = wr_en & wr_data[BIT_THRE] & ~ier_q[BIT_THRE] & thr_empty;
  assign thr_set_w = thr_rise_w | thr_arm_w;
  assign thr_clr_w = clr_thr | ~thr_empty;

  uart_irq_flag u_thr_flag (
    .clk(clk), .rst_n(rst_n), .set(thr_set_w), .clr(thr_clr_w), .q(p_thr_q)
  );
  uart_irq_flag u_xoff_flag (
    .clk(clk), .rst_n(rst_n), .set(xoff_seen), .clr(clr_xoff), .q(p_xoff_q)
  );
  uart_irq_flag u_rts_flag (
    .clk(clk), .rst_n(rst_n), .set(rts_rise_w), .clr(clr_rts), .q(p_rts_q)
  );
  uart_irq_flag u_cts_flag (
    .clk(clk), .rst_n(rst_n), .set(cts_rise_w), .clr(clr_cts), .q(p_cts_q)
  );

  assign line_w  = |lsr_err;
  assign modem_w = |msr_delta;

  always_comb begin
    pending            = '0;
    pending[BIT_RXRDY] = rx_ready;
    pending[BIT_THRE]  = p_thr_q;
    pending[BIT_LINE]  = line_w;
    pending[BIT_MODEM] = modem_w;
    pending[BIT_XOFF]  = p_xoff_q;
    pending[BIT_RTS]   = p_rts_q;
    pending[BIT_CTS]   = p_cts_q;
  end

  assign irq      = irq_any(pending, ier_q);
  assign sleep_en = ier_q[BIT_SLEEP];

endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       xoff_seen,
  input logic       thr_empty,
  input logic       clr_cts,
  input logic       clr_xoff,
  input logic       irq,
  input logic [7:0] pending,
  input logic       sleep_en,
  input logic       cts_rise_w,
  input logic       rts_rise_w
);

  assert_zero_write_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == 8'h00) |=> !irq) else $error("zero enables left irq high");

  assert_sleep_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (sleep_en == $past(wr_data[4]))) else $error("sleep enable mismatch");

  assert_thr_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_empty |=> !pending[1]) else $error("thr pending kept while not empty");

  assert_cts_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cts_rise_w |=> pending[7]) else $error("cts edge not latched");

  assert_rts_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rts_rise_w |=> pending[6]) else $error("rts edge not latched");

  assert_xoff_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_seen |=> pending[5]) else $error("xoff not latched");

  assert_cts_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pending[7] && !clr_cts) |=> pending[7]) else $error("cts pending lost");

  assert_xoff_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_xoff && !xoff_seen) |=> !pending[5]) else $error("xoff clear ignored");

  assert_mask_keeps_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[5] && pending[5] && !clr_xoff) |=> pending[5])
    else $error("masking discarded pending");

endmodule

bind uart_irq_ctrl uart_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .xoff_seen(xoff_seen), .thr_empty(thr_empty), .clr_cts(clr_cts),
  .clr_xoff(clr_xoff), .irq(irq), .pending(pending), .sleep_en(sleep_en),
  .cts_rise_w(cts_rise_w), .rts_rise_w(rts_rise_w)
);

// File: tb/tb_uart_irq_ctrl.sv
`timescale 1ns/1ps
module tb_uart_irq_ctrl;

  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [7:0] wr_data;
  logic rx_ready, thr_empty;
  logic [3:0] lsr_err, msr_delta;
  logic cts_in, rts_level, xoff_seen;
  logic clr_thr, clr_xoff, clr_rts, clr_cts;
  logic irq;
  logic [7:0] pending;
  logic sleep_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  uart_irq_ctrl #(.LSR_W(4), .MSR_W(4), .CTS_SYNC(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rx_ready(rx_ready), .thr_empty(thr_empty), .lsr_err(lsr_err),
    .msr_delta(msr_delta), .cts_in(cts_in), .rts_level(rts_level),
    .xoff_seen(xoff_seen), .clr_thr(clr_thr), .clr_xoff(clr_xoff),
    .clr_rts(clr_rts), .clr_cts(clr_cts), .irq(irq), .pending(pending),
    .sleep_en(sleep_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_en(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  // Expected interrupt: any source bit (not bit 4) pending and enabled.
  function automatic logic model_irq(input logic [7:0] p, input logic [7:0] e);
    logic r = 1'b0;
    for (int b = 0; b < 8; b++)
      if (b != 4 && p[b] && e[b]) r = 1'b1;
    return r;
  endfunction

  task automatic quiet();
    rx_ready = 0; thr_empty = 0; lsr_err = 0; msr_delta = 0;
    rts_level = 0; cts_in = 0; xoff_seen = 0;
    write_en(8'h00);
    clr_thr = 1; clr_xoff = 1; clr_rts = 1; clr_cts = 1;
    step(SYNC + 2);
    clr_thr = 0; clr_xoff = 0; clr_rts = 0; clr_cts = 0;
    step(1);
  endtask

  // Make exactly one source pending (bit index b).
  task automatic raise_src(input int b);
    case (b)
      0: rx_ready = 1;
      1: begin thr_empty = 1; step(1); end
      2: lsr_err = 4'b0100;
      3: msr_delta = 4'b0010;
      5: begin xoff_seen = 1; step(1); xoff_seen = 0; end
      6: begin rts_level = 1; step(1); end
      7: begin cts_in = 1; step(SYNC + 1); end
      default: ;
    endcase
    step(1);
  endtask

  task automatic sweep(input logic [7:0] pexp, input string req);
    for (int e = 0; e < 256; e++) begin
      write_en(e[7:0]);
      chk(req, {31'd0, irq}, {31'd0, model_irq(pexp, e[7:0])});
      chk("R2", {31'd0, sleep_en}, {31'd0, e[4]});
    end
    chk(req, {24'd0, pending}, {24'd0, pexp});
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_data = 0;
    rx_ready = 0; thr_empty = 0; lsr_err = 0; msr_delta = 0;
    cts_in = 1; rts_level = 1; xoff_seen = 0;
    clr_thr = 0; clr_xoff = 0; clr_rts = 0; clr_cts = 0;
    step(3);
    rst_n = 1;
    step(SYNC + 3);
    // R1 reset state; R8/R9 lines high out of reset give no event
    chk("R1", {29'd0, irq, sleep_en, |pending}, 32'd0);
    chk("R8", {31'd0, pending[7]}, 32'd0);
    chk("R9", {31'd0, pending[6]}, 32'd0);
    write_en(8'hFF);
    chk("R1", {31'd0, irq}, 32'd0);
    quiet();

    // R3 single-source sweeps; R4 R5 R6 R7 R10 R9 R8 sources
    for (int b = 0; b < 8; b++) begin
      if (b != 4) begin
        raise_src(b);
        sweep(8'(1 << b), "R3");
        quiet();
      end
    end

    // R3 all sources at once; R2 pending[4] stays 0
    rx_ready = 1; lsr_err = 4'hF; msr_delta = 4'hF;
    raise_src(1); raise_src(5); raise_src(6); raise_src(7);
    sweep(8'hEF, "R3");
    chk("R2", {31'd0, pending[4]}, 32'd0);
    quiet();

    // R5 / R6 every status code
    write_en(8'h0C);
    for (int v = 0; v < 16; v++) begin
      lsr_err = v[3:0]; msr_delta = 4'h0; step(1);
      chk("R5", {30'd0, pending[2], irq}, {30'd0, v != 0, v != 0});
      lsr_err = 4'h0; msr_delta = v[3:0]; step(1);
      chk("R6", {30'd0, pending[3], irq}, {30'd0, v != 0, v != 0});
    end
    quiet();

    // R4 follows level
    rx_ready = 1; #1 chk("R4", {31'd0, pending[0]}, 32'd1);
    rx_ready = 0; #1 chk("R4", {31'd0, pending[0]}, 32'd0);
    step(1);

    // R8 latency exactly SYNC+1 edges, then held after input falls (R11)
    cts_in = 1;
    step(SYNC);
    chk("R8", {31'd0, pending[7]}, 32'd0);
    step(1);
    chk("R8", {31'd0, pending[7]}, 32'd1);
    cts_in = 0; step(SYNC + 2);
    chk("R11", {31'd0, pending[7]}, 32'd1);
    clr_cts = 1; step(1); clr_cts = 0;
    chk("R11", {31'd0, pending[7]}, 32'd0);

    // R9 one-edge latency, held after fall, cleared by strobe (R11)
    rts_level = 1; step(1);
    chk("R9", {31'd0, pending[6]}, 32'd1);
    rts_level = 0; step(2);
    chk("R11", {31'd0, pending[6]}, 32'd1);
    clr_rts = 1; step(1); clr_rts = 0;
    chk("R11", {31'd0, pending[6]}, 32'd0);

    // R11 event beats clear in the same cycle
    xoff_seen = 1; clr_xoff = 1; step(1); xoff_seen = 0; clr_xoff = 0;
    chk("R10", {31'd0, pending[5]}, 32'd1);
    // R12 masking keeps pending
    write_en(8'h20);
    chk("R12", {31'd0, irq}, 32'd1);
    write_en(8'h00);
    chk("R12", {30'd0, irq, pending[5]}, 32'd1);
    write_en(8'h20);
    chk("R12", {31'd0, irq}, 32'd1);
    clr_xoff = 1; step(1); clr_xoff = 0;
    chk("R11", {31'd0, pending[5]}, 32'd0);
    quiet();

    // R7 arm on enable write while empty, drop when not empty
    thr_empty = 1; step(2);
    clr_thr = 1; step(1); clr_thr = 0;
    chk("R7", {31'd0, pending[1]}, 32'd0);
    write_en(8'h02);
    chk("R7", {30'd0, pending[1], irq}, 32'd3);
    write_en(8'h02);
    clr_thr = 1; step(1); clr_thr = 0;
    write_en(8'h02);
    chk("R7", {31'd0, pending[1]}, 32'd0);
    thr_empty = 0; step(1); thr_empty = 1; step(1);
    chk("R7", {31'd0, pending[1]}, 32'd1);
    thr_empty = 0; step(1);
    chk("R7", {30'd0, pending[1], irq}, 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule